// File: doc/BRIEF.md
# Block-Exponent Multi-Operand Floating-Point Adder

This block sums a short run of floating-point operands, from one to eight of them, without doing a separate align, add and normalize step for each pair. The caller first writes operands one at a time through a load port. Each operand has a sign bit, an unsigned mantissa and an unsigned exponent, and its value is (-1)^sign * mantissa * 2^exponent. The caller then pulses start together with an operand count. The block scans the operands once for the largest exponent and uses it as a shared block exponent. It right-shifts every mantissa down to that exponent in a second pass. In a third pass it adds or subtracts the aligned mantissas into a signed accumulator that has three extra high bits of headroom. A single leading-one normalization then produces the result.

Each pass handles one operand per clock, so a run of n operands takes a fixed 3n+1 cycles from start to result. Alignment and normalization truncate, so bits that are shifted out are lost. Keeping the exponent result inside its field is the caller's job: the block performs no range checks, does not round and does not handle special values.

Top module: `block_exp_adder`

## Requirements
- R1: A pulse on `ld_i` in idle writes the operand into the next slot, starting at slot 0. Any `start_i` seen in idle, accepted or rejected, returns the write slot to 0.
- R2: The block exponent is the largest exponent among operand slots 0 to n-1.
- R3: Each mantissa is shifted right by (block exponent − its exponent) before any addition. The bits shifted out are dropped, and a shift of `MANT_W` or more gives zero.
- R4: Aligned mantissas are added when the sign bit is 0 and subtracted when it is 1. With eight full-scale operands the sum does not overflow.
- R5: A nonzero result has `sum_mant_o[MANT_W-1]` = 1. Its `sum_exp_o` equals the block exponent plus the number of places the magnitude was shifted right, or minus the number of places it was shifted left. Right shifts truncate.
- R6: A zero sum gives `sum_mant_o` = 0, `sum_exp_o` = 0 and `sum_sign_o` = 0.
- R7: `done_o` is high for exactly one cycle. That cycle begins 3n+1 rising edges after the edge that samples an accepted start. The result outputs hold their value until the next `done_o`.
- R8: A start with a count of 0 or more than `MAX_OPS` raises `err_o` for one cycle, on the next edge. It raises no `done_o` and leaves the result outputs unchanged.
- R9: `sum_sign_o` is 1 exactly when the signed sum is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_i | input | 1 | Write one operand into the next slot |
| ld_sign_i | input | 1 | Operand sign, 1 = negative |
| ld_mant_i | input | MANT_W | Operand mantissa magnitude |
| ld_exp_i | input | EXP_W | Operand exponent |
| cnt_i | input | CNT_W | Number of operands to sum, sampled with start |
| start_i | input | 1 | Begin a summation |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| err_o | output | 1 | One-cycle pulse for a rejected count |
| sum_sign_o | output | 1 | Result sign |
| sum_mant_o | output | MANT_W | Normalized result mantissa |
| sum_exp_o | output | EXP_W | Result exponent |

## Verification
For n operands the result and `done_o` are due 3n+1 rising edges after the edge that samples start. `err_o` is due on the first edge after the edge that samples a rejected start. The bench drives every input on falling edges. It then counts rising edges and looks at `done_o` on each following falling edge, so it checks that the pulse arrives at exactly that count and reads the result in that same cycle. For rejected starts it samples `err_o` half a cycle after the next edge. It then watches several more cycles and checks that no `done_o` appears and that the held result does not change.

// File: rtl/bea_pkg.sv
package bea_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIND,
    ST_ALIGN,
    ST_ACC,
    ST_NORM,
    ST_DONE
  } bea_state_e;
endpackage

// File: rtl/bea_align.sv
module bea_align #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [EXP_W-1:0]  emax_i,
  output logic [MANT_W-1:0] mant_o
);
  logic [EXP_W-1:0] shamt;
  assign shamt  = emax_i - exp_i;
  assign mant_o = (shamt >= EXP_W'(MANT_W)) ? '0 : (mant_i >> shamt);
endmodule

// File: rtl/bea_lod.sv
module bea_lod #(
  parameter int W     = 11,
  parameter int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [POS_W-1:0] pos_o,
  output logic             found_o
);
  // later hits overwrite earlier ones: highest set bit wins
  always_comb begin
    pos_o   = '0;
    found_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        pos_o   = POS_W'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bea_norm.sv
module bea_norm #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6,
  parameter int MAG_W  = 11
) (
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [EXP_W-1:0]  emax_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [EXP_W-1:0]  exp_o
);
  localparam int POS_W = $clog2(MAG_W);
  localparam int TOP   = MANT_W - 1;

  logic [POS_W-1:0] pos;
  logic             found;
  logic [POS_W-1:0] rsh, lsh;

  bea_lod #(.W(MAG_W), .POS_W(POS_W)) u_lod (
    .vec_i  (mag_i),
    .pos_o  (pos),
    .found_o(found)
  );

  always_comb begin
    mant_o = '0;
    exp_o  = '0;
    rsh    = '0;
    lsh    = '0;
    if (found) begin
      if (int'(pos) >= TOP) begin
        rsh    = POS_W'(int'(pos) - TOP);
        mant_o = MANT_W'(mag_i >> rsh);
        exp_o  = emax_i + EXP_W'(rsh);
      end else begin
        lsh    = POS_W'(TOP - int'(pos));
        mant_o = MANT_W'(mag_i << lsh);
        exp_o  = emax_i - EXP_W'(lsh);
      end
    end
  end
endmodule

// File: rtl/block_exp_adder.sv
module block_exp_adder
  import bea_pkg::*;
#(
  parameter  int MANT_W  = 8,
  parameter  int EXP_W   = 6,
  parameter  int MAX_OPS = 8,
  localparam int GUARD_W = $clog2(MAX_OPS),
  localparam int MAG_W   = MANT_W + GUARD_W,
  localparam int ACC_W   = MAG_W + 1,
  localparam int IDX_W   = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1,
  localparam int CNT_W   = $clog2(MAX_OPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              ld_sign_i,
  input  logic [MANT_W-1:0] ld_mant_i,
  input  logic [EXP_W-1:0]  ld_exp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              start_i,
  output logic              done_o,
  output logic              err_o,
  output logic              sum_sign_o,
  output logic [MANT_W-1:0] sum_mant_o,
  output logic [EXP_W-1:0]  sum_exp_o
);
  localparam int ACC_MAX = MAX_OPS * ((1 << MANT_W) - 1);

  bea_state_e state_q;
  logic [IDX_W-1:0] wr_ptr_q, idx_q;
  logic [CNT_W-1:0] n_q;
  logic [EXP_W-1:0] emax_q;
  logic signed [ACC_W-1:0] acc_q;
  logic err_q, res_sign_q;
  logic [MANT_W-1:0] res_mant_q;
  logic [EXP_W-1:0]  res_exp_q;

  logic [MAX_OPS-1:0]             op_sign_q;
  logic [MAX_OPS-1:0][MANT_W-1:0] op_mant_q;
  logic [MAX_OPS-1:0][EXP_W-1:0]  op_exp_q;

  logic bad_cnt, last_idx, ld_ok;
  logic [MANT_W-1:0] cur_mant, aligned_mant, norm_mant;
  logic [EXP_W-1:0]  cur_exp, norm_exp;
  logic signed [ACC_W-1:0] cur_ext;
  logic [MAG_W-1:0] acc_abs;

  assign bad_cnt  = (cnt_i == '0) || (cnt_i > CNT_W'(MAX_OPS));
  assign last_idx = (CNT_W'(idx_q) == n_q - CNT_W'(1));
  assign ld_ok    = (state_q == ST_IDLE) && ld_i && !start_i;
  assign cur_mant = op_mant_q[idx_q];
  assign cur_exp  = op_exp_q[idx_q];
  assign cur_ext  = $signed({{(ACC_W-MANT_W){1'b0}}, cur_mant});
  assign acc_abs  = acc_q[ACC_W-1] ? MAG_W'(-acc_q) : MAG_W'(acc_q);

  bea_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .mant_i(cur_mant),
    .exp_i (cur_exp),
    .emax_i(emax_q),
    .mant_o(aligned_mant)
  );

  bea_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W), .MAG_W(MAG_W)) u_norm (
    .mag_i (acc_abs),
    .emax_i(emax_q),
    .mant_o(norm_mant),
    .exp_o (norm_exp)
  );

  // operand slots; aligned mantissa overwrites the loaded one in place
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_sign_q <= '0;
      op_mant_q <= '0;
      op_exp_q  <= '0;
    end else begin
      for (int s = 0; s < MAX_OPS; s++) begin
        if (ld_ok && wr_ptr_q == IDX_W'(s)) begin
          op_sign_q[s] <= ld_sign_i;
          op_mant_q[s] <= ld_mant_i;
          op_exp_q[s]  <= ld_exp_i;
        end else if (state_q == ST_ALIGN && idx_q == IDX_W'(s)) begin
          op_mant_q[s] <= aligned_mant;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wr_ptr_q   <= '0;
      idx_q      <= '0;
      n_q        <= '0;
      emax_q     <= '0;
      acc_q      <= '0;
      err_q      <= 1'b0;
      res_sign_q <= 1'b0;
      res_mant_q <= '0;
      res_exp_q  <= '0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            wr_ptr_q <= '0;
            if (bad_cnt) begin
              err_q <= 1'b1;
            end else begin
              n_q     <= cnt_i;
              idx_q   <= '0;
              emax_q  <= '0;
              acc_q   <= '0;
              state_q <= ST_FIND;
            end
          end else if (ld_i) begin
            wr_ptr_q <= (wr_ptr_q == IDX_W'(MAX_OPS - 1)) ? '0 : wr_ptr_q + IDX_W'(1);
          end
        end
        ST_FIND: begin
          if (cur_exp > emax_q) emax_q <= cur_exp;
          idx_q <= last_idx ? '0 : idx_q + IDX_W'(1);
          if (last_idx) state_q <= ST_ALIGN;
        end
        ST_ALIGN: begin
          idx_q <= last_idx ? '0 : idx_q + IDX_W'(1);
          if (last_idx) state_q <= ST_ACC;
        end
        ST_ACC: begin
          acc_q <= op_sign_q[idx_q] ? acc_q - cur_ext : acc_q + cur_ext;
          idx_q <= last_idx ? '0 : idx_q + IDX_W'(1);
          if (last_idx) state_q <= ST_NORM;
        end
        ST_NORM: begin
          res_sign_q <= acc_q[ACC_W-1];
          res_mant_q <= norm_mant;
          res_exp_q  <= norm_exp;
          state_q    <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = (state_q == ST_DONE);
  assign err_o      = err_q;
  assign sum_sign_o = res_sign_q;
  assign sum_mant_o = res_mant_q;
  assign sum_exp_o  = res_exp_q;

  AST_EXP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALIGN) |-> (cur_exp <= emax_q)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(acc_abs) <= ACC_MAX)); // R4
  AST_NORM_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sum_mant_o != '0) |-> sum_mant_o[MANT_W-1]); // R5
  AST_ZERO_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sum_mant_o == '0) |-> (sum_exp_o == '0 && !sum_sign_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_BAD_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && bad_cnt) |=> (err_o && !done_o && $stable(sum_mant_o))); // R8
endmodule

// File: tb/block_exp_adder_tb_top.sv
module block_exp_adder_tb_top;
  localparam int MW = 8;
  localparam int EW = 6;
  localparam int MO = 8;
  localparam int CW = $clog2(MO + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ld_i = 1'b0, ld_sign_i = 1'b0, start_i = 1'b0;
  logic [MW-1:0] ld_mant_i = '0;
  logic [EW-1:0] ld_exp_i = '0;
  logic [CW-1:0] cnt_i = '0;
  logic done_o, err_o, sum_sign_o;
  logic [MW-1:0] sum_mant_o;
  logic [EW-1:0] sum_exp_o;

  int total = 0, bad = 0;
  bit finished = 0;
  int op_s [MO], op_m [MO], op_e [MO];
  int x_sign, x_mant, x_exp;
  int unsigned seed = 32'h1234_5678;

  always #4 clk_i = ~clk_i;

  block_exp_adder #(.MANT_W(MW), .EXP_W(EW), .MAX_OPS(MO)) dut_i (
    .clk_i, .rst_ni, .ld_i, .ld_sign_i, .ld_mant_i, .ld_exp_i,
    .cnt_i, .start_i, .done_o, .err_o, .sum_sign_o, .sum_mant_o, .sum_exp_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic int rnd(input int lim);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'h7fff) % lim;
  endfunction

  // arithmetic reference for slots 0..n-1
  task automatic model(input int n);
    int emax, sum, mag, e;
    emax = 0;
    for (int i = 0; i < n; i++) if (op_e[i] > emax) emax = op_e[i];
    sum = 0;
    for (int i = 0; i < n; i++) begin
      int a;
      a = (emax - op_e[i] >= MW) ? 0 : (op_m[i] / (1 << (emax - op_e[i])));
      sum = op_s[i] ? sum - a : sum + a;
    end
    x_sign = (sum < 0);
    mag = (sum < 0) ? -sum : sum;
    e = emax;
    if (mag == 0) begin
      x_mant = 0; x_exp = 0; x_sign = 0;
    end else begin
      while (mag >= (1 << MW)) begin mag = mag / 2; e++; end
      while (mag < (1 << (MW - 1))) begin mag = mag * 2; e--; end
      x_mant = mag; x_exp = e;
    end
  endtask

  task automatic load_op(input int s, input int m, input int e);
    ld_i = 1'b1; ld_sign_i = s[0]; ld_mant_i = MW'(m); ld_exp_i = EW'(e);
    @(posedge clk_i); @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  task automatic load_all(input int n);
    for (int i = 0; i < n; i++) load_op(op_s[i], op_m[i], op_e[i]);
  endtask

  task automatic run(input int n, input string tag);
    int cyc;
    bit got;
    model(n);
    cnt_i = CW'(n); start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    cyc = 0; got = 0;
    while (!got && cyc < 200) begin
      @(posedge clk_i); cyc++;
      @(negedge clk_i);
      if (done_o) got = 1;
    end
    chk(cyc == 3 * n + 1, {tag, " R7 latency"}, cyc, 3 * n + 1);
    chk(int'(sum_mant_o) == x_mant, {tag, " R3 R4 R5 mant"}, int'(sum_mant_o), x_mant);
    chk(int'(sum_exp_o) == x_exp, {tag, " R2 R5 exp"}, int'(sum_exp_o), x_exp);
    chk(int'(sum_sign_o) == x_sign, {tag, " R9 sign"}, int'(sum_sign_o), x_sign);
    @(posedge clk_i); @(negedge clk_i);
    chk(!done_o, {tag, " R7 single pulse"}, int'(done_o), 0);
  endtask

  task automatic reject(input int c);
    int m0;
    bit seen;
    m0 = int'(sum_mant_o);
    cnt_i = CW'(c); start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R8 err pulse", int'(err_o), 1);
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (done_o || err_o) seen = 1;
    end
    chk(!seen, "R8 no done after reject", int'(seen), 0);
    chk(int'(sum_mant_o) == m0, "R8 result held", int'(sum_mant_o), m0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!done_o && !err_o, "R7 R8 reset flags", int'(done_o) + int'(err_o), 0);
    chk(sum_mant_o == '0 && sum_exp_o == '0, "R6 reset result", int'(sum_mant_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4: eight full-scale operands use all guard bits
    for (int i = 0; i < 8; i++) begin op_s[i] = 0; op_m[i] = 255; op_e[i] = 20; end
    load_all(8); run(8, "R4 fullscale");
    // R6: exact cancellation
    op_s[0] = 0; op_m[0] = 100; op_e[0] = 10;
    op_s[1] = 1; op_m[1] = 100; op_e[1] = 10;
    load_all(2); run(2, "R6 cancel");
    chk(sum_mant_o == '0 && sum_exp_o == '0 && !sum_sign_o, "R6 zero form", int'(sum_exp_o), 0);
    // R5: deep left normalization
    op_s[0] = 0; op_m[0] = 128; op_e[0] = 10;
    op_s[1] = 1; op_m[1] = 127; op_e[1] = 10;
    load_all(2); run(2, "R5 leftshift");
    // R3: gap wider than the mantissa drops the small operand
    op_s[0] = 0; op_m[0] = 200; op_e[0] = 40;
    op_s[1] = 0; op_m[1] = 255; op_e[1] = 30;
    load_all(2); run(2, "R3 widegap");
    // R9: negative result, largest exponent not in slot 0
    op_s[0] = 1; op_m[0] = 90; op_e[0] = 12;
    op_s[1] = 0; op_m[1] = 3;  op_e[1] = 15;
    op_s[2] = 1; op_m[2] = 250; op_e[2] = 15;
    load_all(3); run(3, "R9 negative");

    // R8 and R1: rejected counts, then pointer restart
    op_s[0] = 0; op_m[0] = 5; op_e[0] = 50;
    load_all(2);
    reject(0);
    load_all(2);
    reject(9);
    op_s[0] = 0; op_m[0] = 77; op_e[0] = 30;
    load_all(1); run(1, "R1 slot restart");
    chk(int'(sum_mant_o) == 154 && int'(sum_exp_o) == 29, "R1 new slot0 used", int'(sum_mant_o), 154);

    // sweep all counts with random and clustered exponents
    for (int n = 1; n <= MO; n++) begin
      for (int p = 0; p < 24; p++) begin
        int base;
        base = 12 + rnd(44);
        for (int i = 0; i < n; i++) begin
          op_s[i] = rnd(2);
          op_m[i] = (p % 3 == 0) ? 128 + rnd(128) : rnd(256);
          op_e[i] = (p % 2 == 0) ? 8 + rnd(52) : base - rnd(4);
        end
        load_all(n);
        run(n, "sweep");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule